// File: doc/BRIEF.md
# SPI Register Bank with FIFO Data Ports

This block is the register side of a byte-oriented SPI slave. A separate shift engine turns serial traffic into whole bytes and hands each one over with a single-cycle strobe. The block also supplies the byte that the engine must shift out next. The first byte after chip-select falls is a command that picks a register address and a direction. Each later byte in the same chip-select window is a data byte for the current address.

The 32-entry address space has three regions. Addresses 0 to 4 are FIFO data ports, and the pointer stays on them so that a burst streams through one FIFO. Addresses 5 to 20 are control, status and interrupt registers, and the pointer steps forward after every data byte until it reaches address 20. Addresses 21 to 31 are empty. Each register applies its own per-bit write rule: plain storage, a 7-bit count, a single enable bit, write-one-to-clear flags, a constant, or an externally driven read-only value. The FIFOs themselves live outside the block and are driven through push and pop strobes.

Top module: `spi_regbank`

## Requirements
- R1: The command byte carries the register address in bits 7:3 and the direction in bit 1, where 1 means write. Bits 2 and 0 have no effect.
- R2: On addresses 0 to 4 the pointer does not move. Each written data byte gives one `fifo_push` pulse on bit `addr`, with the byte on `fifo_wdata`. Each read data byte gives one `fifo_pop` pulse on bit `addr`, and successive bytes return successive FIFO heads.
- R3: On addresses 5 to 19 the pointer advances by one after each data byte.
- R4: Once the pointer reaches address 20 it stays there for the rest of the window, and every further byte reads or writes address 20.
- R5: Raising `cs_n` ends the window. The next byte after `cs_n` falls again is treated as a new command.
- R6: Addresses 21 to 31 ignore writes, read 0x00 and produce no FIFO strobes.
- R7: Address 18 always reads 0x02. Address 19 reads the `ro_word` input. Writes to either address have no effect.
- R8: Addresses 11 and 13 hold interrupt flags. Writing 1 to a bit clears it and writing 0 leaves it as it is. A pulse on `evt_a` (address 11) or `evt_b` (address 13) sets the matching bit. When a set and a clear hit the same bit in the same cycle, the set wins.
- R9: Addresses 5 to 8 keep the low 7 bits of a written byte. Bit 7 always reads 0.
- R10: Address 16 keeps only bit 0, which drives `int_en`. Its upper bits read 0.
- R11: Addresses 9, 10, 12, 14, 15, 17 and 20 store and return the whole byte.
- R12: After reset, `tx_byte`, the flags, `int_en` and the strobes are all zero. The read data for a slot shows on `tx_byte` by the third clock edge after the strobe that opens the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; high closes the window |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte from the shift engine |
| tx_byte | output | 8 | Byte to be shifted out in the current slot |
| fifo_rdata | input | 40 | Head byte of each FIFO port, port p in bits 8p+7:8p |
| fifo_push | output | 5 | One-cycle push strobe per FIFO port |
| fifo_pop | output | 5 | One-cycle pop strobe per FIFO port |
| fifo_wdata | output | 8 | Byte that goes with a push |
| evt_a | input | 8 | Set pulses for the flags at address 11 |
| evt_b | input | 8 | Set pulses for the flags at address 13 |
| ro_word | input | 8 | Value returned at address 19 |
| flags_a | output | 8 | Current flags at address 11 |
| flags_b | output | 8 | Current flags at address 13 |
| int_en | output | 1 | Enable bit held at address 16 |

## Verification
The assertions assume that `rx_valid` is a single-cycle pulse with at least three idle cycles after it, the pacing a byte-serial engine gives. They also assume that `rx_valid` is only raised while `cs_n` is low, and that the FIFO head changes in the cycle after a pop. The bench sends every byte through one task that holds the strobe for one cycle and then waits three cycles. It models the FIFOs as counters that advance on the registered pop strobe. Event pulses are one cycle wide and are driven away from the clock edge, sometimes in the same cycle as a clearing write.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 5;
  localparam int FIFO_PORTS  = 5;
  localparam int LAST_REG    = 20;
  localparam int CNT_LAST    = 8;
  localparam int FLAG_A_ADDR = 11;
  localparam int FLAG_B_ADDR = 13;
  localparam int INTEN_ADDR  = 16;
  localparam int REV_ADDR    = 18;
  localparam int EXT_ADDR    = 19;
  localparam int WR_BIT      = 1;
  localparam logic [7:0] REV_VALUE = 8'h02;

  typedef enum logic [2:0] {
    ACC_NONE,   // no storage, reads zero
    ACC_RW,     // full byte storage
    ACC_CNT,    // 7-bit count storage
    ACC_RC,     // write-one-to-clear flags
    ACC_BIT0,   // single enable bit
    ACC_CONST,  // fixed value
    ACC_EXT     // value from an input
  } acc_e;

  function automatic acc_e acc_of(input int a);
    if (a < FIFO_PORTS || a > LAST_REG) return ACC_NONE;
    if (a <= CNT_LAST) return ACC_CNT;
    if (a == FLAG_A_ADDR || a == FLAG_B_ADDR) return ACC_RC;
    if (a == INTEN_ADDR) return ACC_BIT0;
    if (a == REV_ADDR) return ACC_CONST;
    if (a == EXT_ADDR) return ACC_EXT;
    return ACC_RW;
  endfunction

  function automatic logic [7:0] wmask_of(input acc_e k);
    case (k)
      ACC_RW, ACC_RC: return 8'hFF;
      ACC_CNT:        return 8'h7F;
      ACC_BIT0:       return 8'h01;
      default:        return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_tracker.sv
module spi_cmd_tracker #(
  parameter int DW     = 8,
  parameter int AW     = 5,
  parameter int NFIFO  = 5,
  parameter int LAST   = 20,
  parameter int WR_POS = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic          in_frame,
  output logic [AW-1:0] ptr,
  output logic          wr_mode,
  output logic          cmd_ev,
  output logic          data_ev
);
  localparam logic [AW-1:0] FIFO_END = AW'(NFIFO);
  localparam logic [AW-1:0] LAST_A   = AW'(LAST);

  logic [AW-1:0] ptr_nxt;
  logic          unused_cmd_bits;

  assign cmd_ev  = rx_valid && !cs_n && !in_frame;
  assign data_ev = rx_valid && !cs_n && in_frame;
  assign unused_cmd_bits = ^rx_byte;

  // region-dependent pointer step
  always_comb begin
    if (ptr < FIFO_END)     ptr_nxt = ptr;
    else if (ptr < LAST_A)  ptr_nxt = ptr + 1'b1;
    else                    ptr_nxt = ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      ptr      <= '0;
      wr_mode  <= 1'b0;
    end else if (cs_n) begin
      in_frame <= 1'b0;
    end else if (cmd_ev) begin
      in_frame <= 1'b1;
      ptr      <= rx_byte[DW-1 -: AW];
      wr_mode  <= rx_byte[WR_POS];
    end else if (data_ev) begin
      ptr      <= ptr_nxt;
    end
  end
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_regbank_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] evt_a,
  input  logic [DW-1:0] evt_b,
  input  logic [DW-1:0] ro_word,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] flags_a,
  output logic [DW-1:0] flags_b,
  output logic          int_en
);
  localparam int NADDR = 1 << AW;

  logic [DW-1:0] rv [NADDR];

  for (genvar a = 0; a < NADDR; a++) begin : g_reg
    localparam acc_e          KIND = acc_of(a);
    localparam logic [DW-1:0] MASK = DW'(wmask_of(KIND));

    if (KIND == ACC_RW || KIND == ACC_CNT || KIND == ACC_BIT0) begin : g_store
      logic          hit;
      logic [DW-1:0] q;
      assign hit = wr_en && (wr_addr == AW'(a));
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (hit) q <= wr_data & MASK;
      end
      assign rv[a] = q;
    end else if (KIND == ACC_RC) begin : g_flag
      logic          hit;
      logic [DW-1:0] q;
      logic [DW-1:0] setv;
      logic [DW-1:0] clrv;
      assign hit  = wr_en && (wr_addr == AW'(a));
      assign setv = (a == FLAG_A_ADDR) ? evt_a : evt_b;
      assign clrv = hit ? wr_data : '0;
      // set term is OR-ed after the clear, so a set wins
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clrv) | setv;
      end
      assign rv[a] = q;
    end else if (KIND == ACC_CONST) begin : g_const
      assign rv[a] = DW'(REV_VALUE);
    end else if (KIND == ACC_EXT) begin : g_ext
      assign rv[a] = ro_word;
    end else begin : g_none
      assign rv[a] = '0;
    end
  end

  assign rd_data = rv[rd_addr];
  assign flags_a = rv[FLAG_A_ADDR];
  assign flags_b = rv[FLAG_B_ADDR];
  assign int_en  = rv[INTEN_ADDR][0];
endmodule

// File: rtl/spi_fifo_strobes.sv
module spi_fifo_strobes #(
  parameter int DW    = 8,
  parameter int AW    = 5,
  parameter int NFIFO = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_ev,
  input  logic             wr_mode,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [NFIFO-1:0] push,
  output logic [NFIFO-1:0] pop,
  output logic [DW-1:0]    wdata_q
);
  localparam logic [AW-1:0] FIFO_END = AW'(NFIFO);

  for (genvar p = 0; p < NFIFO; p++) begin : g_port
    logic hit;
    assign hit = data_ev && (addr == AW'(p));
    always_ff @(posedge clk) begin
      if (rst) begin
        push[p] <= 1'b0;
        pop[p]  <= 1'b0;
      end else begin
        push[p] <= hit && wr_mode;
        pop[p]  <= hit && !wr_mode;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                           wdata_q <= '0;
    else if (data_ev && wr_mode && (addr < FIFO_END))  wdata_q <= wdata;
  end
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_regbank_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int NFIFO = FIFO_PORTS,
  parameter int LAST  = LAST_REG
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                rx_valid,
  input  logic [DW-1:0]       rx_byte,
  output logic [DW-1:0]       tx_byte,
  input  logic [NFIFO*DW-1:0] fifo_rdata,
  output logic [NFIFO-1:0]    fifo_push,
  output logic [NFIFO-1:0]    fifo_pop,
  output logic [DW-1:0]       fifo_wdata,
  input  logic [DW-1:0]       evt_a,
  input  logic [DW-1:0]       evt_b,
  input  logic [DW-1:0]       ro_word,
  output logic [DW-1:0]       flags_a,
  output logic [DW-1:0]       flags_b,
  output logic                int_en
);
  localparam int            IDX_W    = (NFIFO > 1) ? $clog2(NFIFO) : 1;
  localparam int            NHEAD    = 1 << IDX_W;
  localparam logic [AW-1:0] FIFO_END = AW'(NFIFO);
  localparam logic [AW-1:0] LAST_A   = AW'(LAST);

  logic          in_frame;
  logic [AW-1:0] ptr;
  logic          wr_mode;
  logic          cmd_ev;
  logic          data_ev;
  logic [DW-1:0] reg_rd;
  logic [DW-1:0] rd_sel;
  logic [DW-1:0] fifo_head [NHEAD];
  logic          load1;
  logic          load2;
  logic          reg_wr;

  spi_cmd_tracker #(
    .DW(DW), .AW(AW), .NFIFO(NFIFO), .LAST(LAST), .WR_POS(WR_BIT)
  ) u_trk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .in_frame(in_frame), .ptr(ptr), .wr_mode(wr_mode),
    .cmd_ev(cmd_ev), .data_ev(data_ev)
  );

  assign reg_wr = data_ev && wr_mode && (ptr >= FIFO_END) && (ptr <= LAST_A);

  spi_reg_file #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr), .wr_addr(ptr), .wr_data(rx_byte),
    .rd_addr(ptr),
    .evt_a(evt_a), .evt_b(evt_b), .ro_word(ro_word),
    .rd_data(reg_rd), .flags_a(flags_a), .flags_b(flags_b), .int_en(int_en)
  );

  spi_fifo_strobes #(.DW(DW), .AW(AW), .NFIFO(NFIFO)) u_fifo (
    .clk(clk), .rst(rst), .data_ev(data_ev), .wr_mode(wr_mode),
    .addr(ptr), .wdata(rx_byte),
    .push(fifo_push), .pop(fifo_pop), .wdata_q(fifo_wdata)
  );

  for (genvar h = 0; h < NHEAD; h++) begin : g_head
    if (h < NFIFO) begin : g_real
      assign fifo_head[h] = fifo_rdata[h*DW +: DW];
    end else begin : g_pad
      assign fifo_head[h] = '0;
    end
  end

  assign rd_sel = (ptr < FIFO_END) ? fifo_head[ptr[IDX_W-1:0]] : reg_rd;

  // two-stage delay lets a popped FIFO present its next head
  always_ff @(posedge clk) begin
    if (rst) begin
      load1   <= 1'b0;
      load2   <= 1'b0;
      tx_byte <= '0;
    end else begin
      load1 <= cmd_ev || data_ev;
      load2 <= load1;
      if (load2) tx_byte <= rd_sel;
    end
  end
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int NFIFO = 5,
  parameter int LAST  = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             in_frame,
  input logic [AW-1:0]    ptr,
  input logic             data_ev,
  input logic [NFIFO-1:0] fifo_push,
  input logic [NFIFO-1:0] fifo_pop,
  input logic [DW-1:0]    evt_a,
  input logic [DW-1:0]    flags_a
);
  localparam logic [AW-1:0] FIFO_END = AW'(NFIFO);
  localparam logic [AW-1:0] LAST_A   = AW'(LAST);

  // R2
  fifo_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (data_ev && ptr < FIFO_END) |=> (ptr == $past(ptr)));

  // R3
  ctrl_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (data_ev && ptr >= FIFO_END && ptr < LAST_A) |=> (ptr == $past(ptr) + 1'b1));

  // R4
  ptr_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (data_ev && ptr >= LAST_A) |=> (ptr == $past(ptr)));

  // R5
  frame_close_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !in_frame);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fifo_push, fifo_pop}));

  // R2
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ((|fifo_push) || (|fifo_pop)) |-> $past(data_ev));

  // R8
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_a) |=> ((flags_a & $past(evt_a)) == $past(evt_a)));
endmodule

bind spi_regbank spi_regbank_chk #(
  .AW(AW), .DW(DW), .NFIFO(NFIFO), .LAST(LAST)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .in_frame(in_frame), .ptr(ptr),
  .data_ev(data_ev), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
  .evt_a(evt_a), .flags_a(flags_a)
);

// File: tb/spi_regbank_bench.sv
module spi_regbank_bench;
  localparam int NF = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic [7:0]    tx_byte;
  logic [NF*8-1:0] fifo_rdata;
  logic [NF-1:0] fifo_push;
  logic [NF-1:0] fifo_pop;
  logic [7:0]    fifo_wdata;
  logic [7:0]    evt_a = '0;
  logic [7:0]    evt_b = '0;
  logic [7:0]    ro_word = 8'h5C;
  logic [7:0]    flags_a;
  logic [7:0]    flags_b;
  logic          int_en;

  int vectors = 0;
  int fails   = 0;
  int pop_cnt  [NF];
  int push_cnt [NF];
  logic [7:0] push_last [NF];
  logic [7:0] m [32];

  always #10 clk = ~clk;

  spi_regbank u_spi_regbank (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .fifo_rdata(fifo_rdata), .fifo_push(fifo_push),
    .fifo_pop(fifo_pop), .fifo_wdata(fifo_wdata), .evt_a(evt_a), .evt_b(evt_b),
    .ro_word(ro_word), .flags_a(flags_a), .flags_b(flags_b), .int_en(int_en)
  );

  // external FIFO model: head advances on each pop
  always_comb begin
    for (int p = 0; p < NF; p++)
      fifo_rdata[p*8 +: 8] = 8'(32 * p + 3 + pop_cnt[p]);
  end

  initial begin
    for (int p = 0; p < NF; p++) begin
      pop_cnt[p] = 0; push_cnt[p] = 0; push_last[p] = '0;
    end
  end

  always @(posedge clk) begin
    for (int p = 0; p < NF; p++) begin
      if (fifo_pop[p])  pop_cnt[p] <= pop_cnt[p] + 1;
      if (fifo_push[p]) begin
        push_cnt[p]  <= push_cnt[p] + 1;
        push_last[p] <= fifo_wdata;
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd(input int a, input bit wr);
    return {5'(a), 1'b0, wr, 1'b0};
  endfunction

  // bench model of per-register write rules
  function automatic void model_write(input int a, input logic [7:0] v);
    if (a >= 5 && a <= 8)                 m[a] = v & 8'h7F;           // R9
    else if (a == 11 || a == 13)          m[a] = m[a] & ~v;           // R8
    else if (a == 16)                     m[a] = v & 8'h01;           // R10
    else if (a == 9 || a == 10 || a == 12 || a == 14 || a == 15 ||
             a == 17 || a == 20)          m[a] = v;                   // R11
  endfunction

  function automatic logic [7:0] model_read(input int a);
    if (a == 18) return 8'h02;     // R7
    if (a == 19) return ro_word;   // R7
    if (a > 20)  return 8'h00;     // R6
    return m[a];
  endfunction

  task automatic frame_open();
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame_close();
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, output logic [7:0] got);
    got = tx_byte;
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [7:0] a, input logic [7:0] b);
    evt_a = a; evt_b = b;
    @(negedge clk);
    evt_a = '0; evt_b = '0;
    m[11] = m[11] | a;
    m[13] = m[13] | b;
    @(negedge clk);
  endtask

  task automatic write_one(input int a, input logic [7:0] v);
    logic [7:0] g;
    frame_open();
    send(cmd(a, 1'b1), g);
    send(v, g);
    frame_close();
    model_write(a, v);
  endtask

  task automatic read_one(input int a, output logic [7:0] r);
    logic [7:0] g;
    frame_open();
    send(cmd(a, 1'b0), g);
    send(8'hFF, r);
    frame_close();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog act=timeout exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] g;
    for (int i = 0; i < 32; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    check("R12 tx_byte", tx_byte, 8'h00);
    check("R12 flags_a", flags_a, 8'h00);
    check("R12 flags_b", flags_b, 8'h00);
    check("R12 int_en", {7'd0, int_en}, 8'h00);
    check("R12 strobes", {6'd0, |fifo_push, |fifo_pop}, 8'h00);

    // single-byte sweep over every non-FIFO address (R6 R7 R9 R10 R11 R12)
    for (int a = 5; a < 32; a++) begin
      logic [7:0] v;
      v = 8'(a * 37 + 8'h91);
      write_one(a, v);
      read_one(a, r);
      check($sformatf("R11/R9/R10/R7/R6 addr %0d", a), r, model_read(a));
    end
    check("R10 int_en pin", {7'd0, int_en}, m[16] & 8'h01);

    // second sweep with inverted patterns (R9 R11)
    for (int a = 5; a < 21; a++) begin
      logic [7:0] v;
      v = ~8'(a * 37 + 8'h91);
      write_one(a, v);
      read_one(a, r);
      check($sformatf("R9/R11 inv addr %0d", a), r, model_read(a));
    end

    // burst write from 5 through saturation at 20 (R3 R4)
    frame_open();
    send(cmd(5, 1'b1), g);
    for (int i = 0; i < 20; i++) begin
      int a;
      a = (5 + i > 20) ? 20 : 5 + i;
      send(8'(8'hC0 + i * 3), g);
      model_write(a, 8'(8'hC0 + i * 3));
    end
    frame_close();
    frame_open();
    send(cmd(5, 1'b0), g);
    for (int i = 0; i < 20; i++) begin
      int a;
      a = (5 + i > 20) ? 20 : 5 + i;
      send(8'h00, r);
      check($sformatf("R3/R4 burst slot %0d addr %0d", i, a), r, model_read(a));
    end
    frame_close();

    // burst in empty region: no effect, zeros, no strobes (R6)
    begin
      int pp0, pu0;
      pp0 = 0; pu0 = 0;
      for (int p = 0; p < NF; p++) begin pp0 += pop_cnt[p]; pu0 += push_cnt[p]; end
      frame_open();
      send(cmd(23, 1'b1), g);
      for (int i = 0; i < 4; i++) send(8'hFF, g);
      frame_close();
      frame_open();
      send(cmd(23, 1'b0), g);
      for (int i = 0; i < 4; i++) begin
        send(8'h00, r);
        check("R6 empty burst read", r, 8'h00);
      end
      frame_close();
      for (int p = 0; p < NF; p++) begin pp0 -= pop_cnt[p]; pu0 -= push_cnt[p]; end
      check("R6 no strobes", 8'(pp0 + pu0), 8'h00);
    end

    // FIFO ports: writes push, reads pop successive heads (R2)
    for (int p = 0; p < NF; p++) begin
      int pu, po;
      pu = push_cnt[p]; po = pop_cnt[p];
      frame_open();
      send(cmd(p, 1'b1), g);
      for (int i = 0; i < 3; i++) begin
        send(8'(8'h40 + p * 8 + i), g);
        check($sformatf("R2 push data port %0d", p), push_last[p], 8'(8'h40 + p * 8 + i));
        check($sformatf("R2 push count port %0d", p), 8'(push_cnt[p] - pu), 8'(i + 1));
      end
      frame_close();
      frame_open();
      send(cmd(p, 1'b0), g);
      for (int i = 0; i < 4; i++) begin
        send(8'h00, r);
        check($sformatf("R2 pop head port %0d byte %0d", p, i), r, 8'(32 * p + 3 + po + i));
      end
      frame_close();
      check($sformatf("R2 pop count port %0d", p), 8'(pop_cnt[p] - po), 8'd4);
    end

    // flags: set by events, write-one clears (R8)
    pulse_evt(8'hFF, 8'hA5);
    check("R8 flags_a after set", flags_a, m[11]);
    check("R8 flags_b after set", flags_b, m[13]);
    write_one(11, 8'h0F);
    read_one(11, r);
    check("R8 clear low nibble", r, 8'hF0);
    write_one(13, 8'h00);
    read_one(13, r);
    check("R8 write zero keeps", r, m[13]);

    // set and clear of same bit in one cycle: set wins (R8)
    frame_open();
    send(cmd(11, 1'b1), g);
    rx_byte  = 8'hF0;
    rx_valid = 1'b1;
    evt_a    = 8'h10;
    @(negedge clk);
    rx_valid = 1'b0;
    evt_a    = 8'h00;
    repeat (3) @(negedge clk);
    frame_close();
    m[11] = (m[11] & ~8'hF0) | 8'h10;
    check("R8 set beats clear", flags_a, 8'h10);

    // ignored command bits (R1)
    frame_open();
    send({5'd9, 3'b111}, g);
    send(8'h3C, g);
    frame_close();
    m[9] = 8'h3C;
    frame_open();
    send({5'd9, 3'b101}, g);
    send(8'h00, r);
    frame_close();
    check("R1 extra bits ignored", r, 8'h3C);
    check("R1 read bit left reg unchanged", m[9], 8'h3C);

    // new window restarts with a command byte (R5)
    write_one(12, 8'h77);
    frame_open();
    send(cmd(9, 1'b1), g);
    send(8'h21, g);
    model_write(9, 8'h21);
    frame_close();
    frame_open();
    send(cmd(12, 1'b0), g);
    send(8'h00, r);
    frame_close();
    check("R5 fresh command after cs", r, 8'h77);
    read_one(10, r);
    check("R5 neighbour untouched", r, m[10]);

    // external read-only value follows its input (R7)
    ro_word = 8'hE4;
    read_one(19, r);
    check("R7 ro_word readback", r, 8'hE4);
    write_one(18, 8'h55);
    read_one(18, r);
    check("R7 constant after write", r, 8'h02);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule